// File: doc/BRIEF.md
# Quadratic Phase Accumulator NCO

This block produces a running phase value for a quadrature mixer that sits ahead of a polyphase filter bank. The phase is not a fixed-frequency ramp. It follows a second-order model in the sample index n: phase(n) = p0 + p1·n + p2·n². The block computes this with two nested accumulators and no multiplier. An inner sum grows by 2·p2 on every sample. The outer phase grows by p1 + p2 plus the current inner sum.

A coefficient load strobe captures the three model terms and restarts the model at n = 0, with the phase set to p0. After that, every asserted sample-valid advances n by one. Both accumulators wrap modulo 2^CW because phase is cyclic. The top bits of the phase go to the mixer's sine/cosine lookup, which lies outside this block.

A two-state controller sequences the block. ST_IDLE is entered from reset and means no coefficients have been loaded yet. In this state the phase stays at zero and samples are ignored. The transition IDLE→RUN fires on the load strobe. ST_RUN advances the model on each valid sample. The transition RUN→RUN on a load strobe is the reload: it reseeds the model from the new coefficients. There is no path back to ST_IDLE except reset.

Top module: `qphase_nco`

## Requirements
- R1: After reset, phase_out is 0 and the controller is in ST_IDLE.
- R2: In ST_IDLE, sample_valid has no effect: phase_out stays 0 until the first load strobe.
- R3: A load strobe captures p0_in, p1_in and p2_in and clears the inner sum. From the cycle after the strobe's clock edge, the phase equals p0 and n = 0.
- R4: In ST_RUN, each cycle with sample_valid high (and load low) increments n by one. The phase then equals p0 + p1·n + p2·n², taken modulo 2^CW.
- R5: With both sample_valid and load low, the phase and the inner sum hold their values.
- R6: All sums wrap modulo 2^CW. Coefficients near 2^CW give the same wrapped phase as the closed-form model.
- R7: phase_out is bits [CW-1:CW-OW] of the phase (OW = 16, CW = 48 by default). It is updated one clock edge after the input that caused the change.
- R8: When load and sample_valid are high in the same cycle, the load wins and the sample is not counted (n = 0 after that edge).
- R9: A load while in ST_RUN restarts the model at n = 0 with the new coefficients. Nothing from the earlier run carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_load | input | 1 | Captures coefficients and restarts the model |
| p0_in | input | CW | Constant phase term |
| p1_in | input | CW | Linear phase term |
| p2_in | input | CW | Quadratic phase term |
| sample_valid | input | 1 | Advances the model by one sample |
| phase_out | output | OW | Top phase bits for the mixer |

## Verification
The checks on the inner sum and the hold behaviour take the coefficient inputs to be meaningful only in a cycle where coef_load is high. Between strobes they may change freely without affecting the step. The check on the seeded phase assumes p0_in is steady during the strobe cycle. The bench drives all inputs on the falling edge, so each input is stable across the capturing rising edge. The bench also changes the coefficient inputs between loads, which shows that only the values captured at a strobe are used.

// File: rtl/qphase_nco_pkg.sv
package qphase_nco_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } nco_state_t;
endpackage

// File: rtl/qphase_nco_ctrl.sv
module qphase_nco_ctrl
    import qphase_nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_req,
    input  logic       smp_req,
    output nco_state_t state,
    output logic       do_seed,
    output logic       do_step
);
    nco_state_t state_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n = state;
        do_seed = 1'b0;
        do_step = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (load_req) begin
                    do_seed = 1'b1;
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (load_req) begin
                    do_seed = 1'b1;
                end else if (smp_req) begin
                    do_step = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/qphase_coef_bank.sv
module qphase_coef_bank #(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [CW-1:0] lin_in,
    input  logic [CW-1:0] quad_in,
    output logic [CW-1:0] outer_step,
    output logic [CW-1:0] inner_step
);
    // p0 needs no storage: it seeds the phase directly.
    // The sums the accumulators need are prepared here, at capture time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_step <= '0;
            inner_step <= '0;
        end else if (capture) begin
            outer_step <= lin_in + quad_in;
            inner_step <= {quad_in[CW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/qphase_accum.sv
module qphase_accum #(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed,
    input  logic          step,
    input  logic [CW-1:0] seed_val,
    input  logic [CW-1:0] outer_step,
    input  logic [CW-1:0] inner_step,
    output logic [CW-1:0] phase_q,
    output logic [CW-1:0] inner_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            inner_q <= '0;
        end else if (seed) begin
            phase_q <= seed_val;
            inner_q <= '0;
        end else if (step) begin
            phase_q <= phase_q + outer_step + inner_q;
            inner_q <= inner_q + inner_step;
        end
    end
endmodule

// File: rtl/qphase_nco.sv
module qphase_nco
    import qphase_nco_pkg::*;
#(
    parameter int CW = 48,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_load,
    input  logic [CW-1:0] p0_in,
    input  logic [CW-1:0] p1_in,
    input  logic [CW-1:0] p2_in,
    input  logic          sample_valid,
    output logic [OW-1:0] phase_out
);
    localparam int OUT_LSB = CW - OW;

    nco_state_t    state;
    logic          do_seed;
    logic          do_step;
    logic [CW-1:0] outer_step;
    logic [CW-1:0] inner_step;
    logic [CW-1:0] phase_acc;
    logic [CW-1:0] inner_acc;

    qphase_nco_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (coef_load),
        .smp_req  (sample_valid),
        .state    (state),
        .do_seed  (do_seed),
        .do_step  (do_step)
    );

    qphase_coef_bank #(.CW(CW)) u_coef (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (do_seed),
        .lin_in     (p1_in),
        .quad_in    (p2_in),
        .outer_step (outer_step),
        .inner_step (inner_step)
    );

    qphase_accum #(.CW(CW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed       (do_seed),
        .step       (do_step),
        .seed_val   (p0_in),
        .outer_step (outer_step),
        .inner_step (inner_step),
        .phase_q    (phase_acc),
        .inner_q    (inner_acc)
    );

    generate
        if (OW >= CW) begin : g_full
            assign phase_out = OW'(phase_acc);
        end else begin : g_slice
            assign phase_out = phase_acc[CW-1:OUT_LSB];
        end
    endgenerate
endmodule

// File: rtl/qphase_nco_chk.sv
module qphase_nco_chk
    import qphase_nco_pkg::*;
#(
    parameter int CW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          coef_load,
    input logic          sample_valid,
    input logic [CW-1:0] p0_in,
    input logic [CW-1:0] p2_in,
    input nco_state_t    state,
    input logic [CW-1:0] phase_acc,
    input logic [CW-1:0] inner_acc
);
    logic [CW-1:0] p2_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)         p2_seen <= '0;
        else if (coef_load) p2_seen <= p2_in;
    end

    assert_idle_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !coef_load) |=> (phase_acc == '0));

    assert_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_load |=> (inner_acc == '0 && phase_acc == $past(p0_in)));

    assert_inner_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sample_valid && !coef_load)
        |=> (inner_acc - $past(inner_acc) == (p2_seen << 1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!coef_load && !sample_valid) |=> ($stable(phase_acc) && $stable(inner_acc)));

    assert_reload_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coef_load |=> (state == ST_RUN));
endmodule

bind qphase_nco qphase_nco_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .coef_load    (coef_load),
    .sample_valid (sample_valid),
    .p0_in        (p0_in),
    .p2_in        (p2_in),
    .state        (state),
    .phase_acc    (phase_acc),
    .inner_acc    (inner_acc)
);

// File: tb/qphase_nco_tb.sv
`timescale 1ns/1ps
module qphase_nco_tb;
    localparam int CW = 48;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_load = 1'b0;
    logic [CW-1:0] p0_in = '0, p1_in = '0, p2_in = '0;
    logic          sample_valid = 1'b0;
    logic [OW-1:0] phase_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    bit            m_loaded = 0;
    logic [CW-1:0] m_p0 = '0, m_p1 = '0, m_p2 = '0, m_n = '0;

    always #4 clk = ~clk;

    qphase_nco #(.CW(CW), .OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .coef_load(coef_load),
        .p0_in(p0_in), .p1_in(p1_in), .p2_in(p2_in),
        .sample_valid(sample_valid), .phase_out(phase_out)
    );

    function automatic logic [OW-1:0] model_out();
        logic [CW-1:0] full;
        if (!m_loaded) return '0;
        full = m_p0 + m_p1 * m_n + m_p2 * m_n * m_n;
        return full[CW-1:CW-OW];
    endfunction

    task automatic check(string req);
        logic [OW-1:0] exp_v;
        exp_v = model_out();
        compared++;
        if (phase_out !== exp_v) begin
            mismatched++;
            $display("FAIL %s: phase_out=%h expected=%h (n=%0d)", req, phase_out, exp_v, m_n);
        end
    endtask

    // one clock: inputs already driven; update model at the edge, compare after
    task automatic cycle(input bit ld, input bit sv,
                         input logic [CW-1:0] a, input logic [CW-1:0] b, input logic [CW-1:0] c);
        coef_load = ld; sample_valid = sv;
        p0_in = a; p1_in = b; p2_in = c;
        @(posedge clk);
        if (rst_n) begin
            if (ld) begin
                m_loaded = 1; m_p0 = a; m_p1 = b; m_p2 = c; m_n = '0;
            end else if (sv && m_loaded) begin
                m_n = m_n + 1;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        check("R1");
        // R2: samples ignored before the first load
        tag = "R2";
        for (int i = 0; i < 6; i++) cycle(0, 1, 48'h1234_5678_9ABC, 48'h1, 48'h1);
        // R3 + R7: load seeds the phase
        tag = "R3";
        cycle(1, 0, 48'hA000_0000_0000, 48'h0000_1234_5678, 48'h0000_0000_4321);
        // coefficient inputs change after load: must not matter
        // R4: run with every cycle valid
        tag = "R4";
        for (int i = 0; i < 40; i++) cycle(0, 1, 48'hFFFF, 48'h7777, 48'h5555);
        // R5: gaps in sample_valid hold the phase
        tag = "R5";
        for (int i = 0; i < 30; i++) cycle(0, (i % 3) == 0, '0, '0, '0);
        // R7: larger quadratic term so upper bits move quickly
        tag = "R7";
        cycle(1, 0, 48'h0000_0000_0000, 48'h0100_0000_0000, 48'h0003_0000_0000);
        for (int i = 0; i < 25; i++) cycle(0, 1, '0, '0, '0);
        // R6: coefficients near 2^CW force wrap in every sum
        tag = "R6";
        cycle(1, 0, 48'hFFFF_FFFF_FF00, 48'hFFFF_FFF0_0000, 48'hFFFF_FFFF_FFFD);
        for (int i = 0; i < 60; i++) cycle(0, 1, '0, '0, '0);
        // R8: load and sample in the same cycle
        tag = "R8";
        for (int i = 0; i < 5; i++) cycle(0, 1, '0, '0, '0);
        cycle(1, 1, 48'h1111_0000_0000, 48'h0222_0000_0000, 48'h0000_4000_0000);
        cycle(0, 0, '0, '0, '0);
        // R9: reload mid-stream restarts from n = 0
        tag = "R9";
        for (int i = 0; i < 12; i++) cycle(0, 1, '0, '0, '0);
        cycle(1, 0, 48'h8000_0000_0000, 48'hFFF0_0000_0000, 48'h0010_0000_0000);
        for (int i = 0; i < 20; i++) cycle(0, (i % 4) != 1, 48'h5, 48'h6, 48'h7);
        // mixed pattern
        tag = "R4";
        for (int i = 0; i < 50; i++) cycle(0, ((i * 7) % 5) < 3, '0, '0, '0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule